// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs the external bus cycles of a 16-bit processor core on a shared set of address/data pins. The core raises a request carrying a 20-bit address, a direction (read or write), a space (memory or I/O), a width (byte or word) and write data. The block then walks through a fixed sequence of bus clocks. It puts the address on the shared pins and pulses the address strobe. It turns the pins around for data and asserts the read or write command together with the transceiver enable. It stretches the cycle while the target holds `ready` low, and it returns the read data with a one-clock done pulse.

Between cycles the block can hand the bus to another master. When `hold` is seen at a cycle boundary, it raises `hlda`, floats every bus output and starts nothing new until `hold` falls. A reset pulse aborts any activity. The block only accepts work after the reset has been held for a minimum number of consecutive clocks.

Top module: `mux_bus_sequencer`

## Requirements
- R1: The clock after a request is accepted is the address clock (T1). In T1, `ad_out` carries address bits 15..0, `a_hi` carries address bits 19..16, and `ad_oe` and `ale` are high. `ale` is high in no other clock.
- R2: In every clock after T1 up to the end of the cycle, `a_hi` carries a phase tag: bit 3 = 1, bit 2 = word, bit 1 = write, bit 0 = I/O.
- R3: For a read, `rd_n` is low from the clock after T1 through the last data clock, `dt_r` is low for the whole cycle, and `ad_oe` is low after T1. `rd_data` shows the `ad_in` value sampled at the end of the last data clock (T3) and is valid while `cyc_done` is high.
- R4: For a write, `wr_n` is low over the same clocks in which a read would hold `rd_n` low. `dt_r` is high for the whole cycle. `ad_oe` stays high through the final clock, and `ad_out` carries the write data after T1.
- R5: `den_n` is low exactly in the command clocks (T2, wait clocks, T3) and high in T1, in T4 and while idle.
- R6: With `ready` high, a cycle lasts 4 clocks from T1 to the `cyc_done` clock. Each clock edge at the end of T2 or of a wait clock where `ready` is low adds one wait clock, with the command held.
- R7: `m_io` is high during the cycle for an I/O access and low for a memory access.
- R8: From T1 to the end of the cycle, `bhe_n` is low for a word transfer and for a byte transfer with address bit 0 set. It is high for an even-address byte transfer and while idle.
- R9: `hold` is acted on only when idle or in the final clock (T4). A `hold` raised during a cycle lets that cycle finish, and `hlda` rises the clock after T4. While `hlda` is high, `bus_oe` and `ad_oe` are low. When idle, `hold` wins over a pending request.
- R10: `hlda` falls the clock after `hold` is sampled low. A pending request then gets its T1 one clock later.
- R11: A clock edge with `rst` high ends any cycle: commands, strobe and drivers go inactive. Requests and `hold` are honoured only after `rst` has been high for at least 4 consecutive clocks. After a shorter pulse, the block stays idle until a full-length reset.
- R12: `cyc_done` is high for exactly one clock (T4) per cycle, and in that clock the commands and `den_n` are already inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Active-high reset, qualified by length |
| req_valid | input | 1 | Core requests a cycle; held until `cyc_done` |
| req_addr | input | 20 | Byte address of the transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data returned to the core |
| cyc_done | output | 1 | One-clock end-of-cycle pulse |
| ad_out | output | 16 | Shared address/data pins, outgoing value |
| ad_in | input | 16 | Shared address/data pins, incoming value |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| a_hi | output | 4 | Upper address in T1, phase tag afterwards |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read command, active low |
| wr_n | output | 1 | Write command, active low |
| den_n | output | 1 | Transceiver enable, active low |
| dt_r | output | 1 | Transceiver direction, 1 = outgoing |
| m_io | output | 1 | 1 = I/O space, 0 = memory |
| bhe_n | output | 1 | Upper byte lane enable, active low |
| bus_oe | output | 1 | Drive enable for the control and upper pins; low while granted away |
| ready | input | 1 | Target ready; low inserts wait clocks |
| hold | input | 1 | External master requests the bus |
| hlda | output | 1 | Bus granted to the external master |

## Verification
Two things can land in the same clock: the end-of-cycle boundary, where `hold` is examined, and either a new request or a `hold` raised during an unfinished cycle. The bench raises `hold` and `req_valid` in the same idle clock and expects `hlda` with no `ale` until `hold` drops. It also raises `hold` during T2 of a read and expects the command to stay asserted through T3, `cyc_done` to arrive with `hlda` still low, and `hlda` one clock later. A reset edge that falls inside a write cycle is judged by all strobes and drivers going inactive in the next clock.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

   // Bus phase of the sequencer; T-states follow each other in this order.
   typedef enum logic [2:0] {
      BS_IDLE = 3'd0,
      BS_T1   = 3'd1,
      BS_T2   = 3'd2,
      BS_TW   = 3'd3,
      BS_T3   = 3'd4,
      BS_T4   = 3'd5,
      BS_HOLD = 3'd6
   } bus_state_e;

   // Width of the phase tag shown on the upper lines after T1.
   localparam int TAG_W = 4;

endpackage

// File: rtl/mbs_reset_qual.sv
module mbs_reset_qual #(
   parameter int RST_MIN = 4
) (
   input  logic clk,
   input  logic rst,
   output logic run_ok
);
   localparam int CNT_W = $clog2(RST_MIN + 1);

   generate
      if (RST_MIN < 1) begin : g_bad_min
         $error("mbs_reset_qual: RST_MIN must be at least 1");
      end

      if (RST_MIN == 1) begin : g_single
         // Any reset edge is long enough.
         assign run_ok = 1'b1;
      end else begin : g_count
         logic             rst_q;
         logic [CNT_W-1:0] rst_cnt;

         always_ff @(posedge clk) begin
            rst_q <= rst;
            if (rst) begin
               if (!rst_q)
                  rst_cnt <= CNT_W'(1);
               else if (rst_cnt != CNT_W'(RST_MIN))
                  rst_cnt <= rst_cnt + CNT_W'(1);
            end
         end

         assign run_ok = (rst_cnt == CNT_W'(RST_MIN));
      end
   endgenerate

endmodule

// File: rtl/mbs_cycle_fsm.sv
module mbs_cycle_fsm
   import mbs_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              run_ok,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_io,
   input  logic              req_word,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              ready,
   input  logic              hold,
   input  logic [DATA_W-1:0] ad_in,
   output bus_state_e        state,
   output logic              lat_write,
   output logic              lat_io,
   output logic              lat_word,
   output logic [ADDR_W-1:0] lat_addr,
   output logic [DATA_W-1:0] lat_wdata,
   output logic [DATA_W-1:0] rd_data
);
   bus_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         BS_IDLE: begin
            if (run_ok && hold)           nxt = BS_HOLD;
            else if (run_ok && req_valid) nxt = BS_T1;
         end
         BS_T1:   nxt = BS_T2;
         BS_T2:   nxt = ready ? BS_T3 : BS_TW;
         BS_TW:   nxt = ready ? BS_T3 : BS_TW;
         BS_T3:   nxt = BS_T4;
         BS_T4:   nxt = hold ? BS_HOLD : BS_IDLE;
         BS_HOLD: nxt = hold ? BS_HOLD : BS_IDLE;
         default: nxt = BS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= BS_IDLE;
         lat_write <= 1'b0;
         lat_io    <= 1'b0;
         lat_word  <= 1'b0;
         lat_addr  <= '0;
         lat_wdata <= '0;
         rd_data   <= '0;
      end else begin
         state <= nxt;
         if (state == BS_IDLE && nxt == BS_T1) begin
            lat_write <= req_write;
            lat_io    <= req_io;
            lat_word  <= req_word;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
         end
         if (state == BS_T3 && !lat_write)
            rd_data <= ad_in;
      end
   end

   // R6
   wait_stretch_chk: assert property (@(posedge clk) disable iff (rst)
      ((state == BS_T2 || state == BS_TW) && !ready) |=> (state == BS_TW));

   // R9
   hold_boundary_chk: assert property (@(posedge clk) disable iff (rst)
      (state == BS_HOLD) |-> ($past(state) == BS_IDLE || $past(state) == BS_T4
                              || $past(state) == BS_HOLD));

   // R3
   read_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (state == BS_T4 && !lat_write) |-> (rd_data == $past(ad_in)));

endmodule

// File: rtl/mbs_pin_drive.sv
module mbs_pin_drive
   import mbs_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  bus_state_e        state,
   input  logic              lat_write,
   input  logic              lat_io,
   input  logic              lat_word,
   input  logic [ADDR_W-1:0] lat_addr,
   input  logic [DATA_W-1:0] lat_wdata,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [ADDR_W-DATA_W-1:0] a_hi,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic              den_n,
   output logic              dt_r,
   output logic              m_io,
   output logic              bhe_n,
   output logic              bus_oe,
   output logic              hlda,
   output logic              cyc_done
);
   localparam int HI_W = ADDR_W - DATA_W;

   logic            in_cyc, cmd_ph, addr_ph;
   logic [HI_W-1:0] tag;

   assign addr_ph = (state == BS_T1);
   assign cmd_ph  = (state == BS_T2) || (state == BS_TW) || (state == BS_T3);
   assign in_cyc  = addr_ph || cmd_ph || (state == BS_T4);
   assign tag     = {1'b1, lat_word, lat_write, lat_io};

   assign ale      = addr_ph;
   assign ad_out   = addr_ph ? lat_addr[DATA_W-1:0] : lat_wdata;
   assign ad_oe    = addr_ph || (in_cyc && lat_write);
   assign a_hi     = addr_ph ? lat_addr[ADDR_W-1:DATA_W] : (in_cyc ? tag : '0);
   assign rd_n     = !(cmd_ph && !lat_write);
   assign wr_n     = !(cmd_ph && lat_write);
   assign den_n    = !cmd_ph;
   assign dt_r     = in_cyc ? lat_write : 1'b1;
   assign m_io     = in_cyc && lat_io;
   assign bhe_n    = !(in_cyc && (lat_word || lat_addr[0]));
   assign hlda     = (state == BS_HOLD);
   assign bus_oe   = !hlda;
   assign cyc_done = (state == BS_T4);

endmodule

// File: rtl/mux_bus_sequencer.sv
module mux_bus_sequencer
   import mbs_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int DATA_W  = 16,
   parameter int RST_MIN = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_io,
   input  logic              req_word,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              cyc_done,
   output logic [DATA_W-1:0] ad_out,
   input  logic [DATA_W-1:0] ad_in,
   output logic              ad_oe,
   output logic [ADDR_W-DATA_W-1:0] a_hi,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic              den_n,
   output logic              dt_r,
   output logic              m_io,
   output logic              bhe_n,
   output logic              bus_oe,
   input  logic              ready,
   input  logic              hold,
   output logic              hlda
);
   localparam int HI_W = ADDR_W - DATA_W;

   generate
      if (HI_W != TAG_W) begin : g_bad_split
         $error("mux_bus_sequencer: ADDR_W - DATA_W must equal the tag width");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("mux_bus_sequencer: DATA_W too small");
      end
   endgenerate

   bus_state_e        state;
   logic              run_ok;
   logic              lat_write, lat_io, lat_word;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_wdata;

   mbs_reset_qual #(.RST_MIN(RST_MIN)) i_rq (
      .clk(clk), .rst(rst), .run_ok(run_ok)
   );

   mbs_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
      .clk(clk), .rst(rst), .run_ok(run_ok),
      .req_valid(req_valid), .req_write(req_write), .req_io(req_io),
      .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
      .ready(ready), .hold(hold), .ad_in(ad_in),
      .state(state), .lat_write(lat_write), .lat_io(lat_io),
      .lat_word(lat_word), .lat_addr(lat_addr), .lat_wdata(lat_wdata),
      .rd_data(rd_data)
   );

   mbs_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pins (
      .state(state), .lat_write(lat_write), .lat_io(lat_io),
      .lat_word(lat_word), .lat_addr(lat_addr), .lat_wdata(lat_wdata),
      .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale),
      .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r),
      .m_io(m_io), .bhe_n(bhe_n), .bus_oe(bus_oe), .hlda(hlda),
      .cyc_done(cyc_done)
   );

   // R1
   ale_single_chk: assert property (@(posedge clk) disable iff (rst)
      ale |=> !ale);

   // R3 R4
   cmd_after_ale_chk: assert property (@(posedge clk) disable iff (rst)
      ($fell(rd_n) || $fell(wr_n)) |-> $past(ale));

   // R9
   grant_clean_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(hlda) |-> ($past(rd_n) && $past(wr_n) && $past(den_n)));

   // R12
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      cyc_done |=> !cyc_done);

   // R11
   unqualified_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !run_ok |-> (!ale && !hlda));

endmodule

// File: tb/test_mux_bus_sequencer.sv
module test_mux_bus_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 6;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0, req_word = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0, ad_in = '0;
   logic        ready = 1'b1, hold = 1'b0;
   logic [15:0] rd_data, ad_out;
   logic [3:0]  a_hi;
   logic        cyc_done, ad_oe, ale, rd_n, wr_n, den_n, dt_r, m_io, bhe_n, bus_oe, hlda;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // {write, io, word, addr[20], wdata[16], read value[16], waits[3]}
   localparam logic [57:0] VECS [NV] = '{
      {1'b0, 1'b0, 1'b1, 20'h12344, 16'h0000, 16'hBEEF, 3'd0},
      {1'b1, 1'b0, 1'b0, 20'hABCD1, 16'h5A5A, 16'h0000, 3'd0},
      {1'b0, 1'b1, 1'b0, 20'h003F8, 16'h0000, 16'h00C3, 3'd2},
      {1'b1, 1'b1, 1'b1, 20'h00061, 16'h1234, 16'h0000, 3'd1},
      {1'b0, 1'b0, 1'b0, 20'hFFFFF, 16'h0000, 16'hA55A, 3'd3},
      {1'b1, 1'b0, 1'b0, 20'h80000, 16'hCAFE, 16'h0000, 3'd0}
   };

   mux_bus_sequencer i_mux_bus_sequencer (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_io(req_io), .req_word(req_word),
      .req_wdata(req_wdata), .rd_data(rd_data), .cyc_done(cyc_done),
      .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .a_hi(a_hi),
      .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r),
      .m_io(m_io), .bhe_n(bhe_n), .bus_oe(bus_oe), .ready(ready),
      .hold(hold), .hlda(hlda)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic report;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not end, actual=%0d expected<20000", cycles);
         report();
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle_pins(input string tag);
      logic [8:0] act, exp;
      act = {ale, rd_n, wr_n, den_n, bhe_n, ad_oe, hlda, bus_oe, cyc_done};
      exp = 9'b0_1111_0010;
      chk(act == exp, tag, 32'(act), 32'(exp));
   endtask

   task automatic apply_reset(input int n);
      @(negedge clk);
      rst = 1'b1;
      repeat (n) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic wait_done;
      for (int g = 0; g < 40 && !cyc_done; g++) @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic run_cycle(input logic [57:0] v);
      logic w, io, wd;
      logic [19:0] a;
      logic [15:0] wdat, rv;
      int nw, k, total;
      bit held;
      w = v[57]; io = v[56]; wd = v[55]; a = v[54:35];
      wdat = v[34:19]; rv = v[18:3]; nw = int'(v[2:0]);
      @(negedge clk);
      req_write = w; req_io = io; req_word = wd; req_addr = a; req_wdata = wdat;
      req_valid = 1'b1; ready = 1'b1; ad_in = 16'h0;
      @(negedge clk); // T1
      chk({ale, ad_oe, a_hi, ad_out} == {2'b11, a}, "R1 address clock",
          32'({ale, ad_oe, a_hi, ad_out}), 32'({2'b11, a}));
      chk(bhe_n == !(wd || a[0]), "R8 lane enable", 32'(bhe_n), 32'(!(wd || a[0])));
      chk(m_io == io, "R7 space select", 32'(m_io), 32'(io));
      chk(dt_r == w, "R3 R4 direction", 32'(dt_r), 32'(w));
      chk(den_n == 1'b1, "R5 den off in T1", 32'(den_n), 32'h1);
      @(negedge clk); // T2
      chk(a_hi == {1'b1, wd, w, io}, "R2 phase tag", 32'(a_hi), 32'({1'b1, wd, w, io}));
      chk({ale, rd_n, wr_n, den_n} == {1'b0, w, !w, 1'b0}, "R3 R4 R5 command clock",
          32'({ale, rd_n, wr_n, den_n}), 32'({1'b0, w, !w, 1'b0}));
      chk(ad_oe == w && (!w || ad_out == wdat), "R4 data drive",
          32'({ad_oe, ad_out}), 32'({w, w ? wdat : ad_out}));
      ad_in = rv;
      ready = (nw == 0);
      k = 0; total = 2; held = 1'b1;
      for (int g = 0; g < 20 && !cyc_done; g++) begin
         @(negedge clk);
         total++;
         if (!cyc_done) begin
            if ((w ? wr_n : rd_n) != 1'b0 || den_n != 1'b0) held = 1'b0;
            if (k < nw) begin
               k++;
               ready = (k == nw);
            end
         end
      end
      chk(held, "R6 command held over waits", 32'(held), 32'h1);
      chk(total == 4 + nw, "R6 cycle length", 32'(total), 32'(4 + nw));
      chk({rd_n, wr_n, den_n, cyc_done} == 4'b1111, "R12 done clock",
          32'({rd_n, wr_n, den_n, cyc_done}), 32'hF);
      chk(ad_oe == w, "R4 write data held in T4", 32'(ad_oe), 32'(w));
      if (!w) chk(rd_data == rv, "R3 read data", 32'(rd_data), 32'(rv));
      ad_in = ~rv;
      req_valid = 1'b0;
      @(negedge clk);
      chk(cyc_done == 1'b0 && ale == 1'b0, "R12 single done",
          32'({cyc_done, ale}), 32'h0);
   endtask

   initial begin
      apply_reset(5);
      @(negedge clk);
      idle_pins("R11 reset state");

      // main table
      for (int i = 0; i < NV; i++) run_cycle(VECS[i]);

      // R9: hold and request in the same idle clock
      @(negedge clk);
      req_write = 1'b0; req_io = 1'b0; req_word = 1'b1; req_addr = 20'h00010;
      req_valid = 1'b1; hold = 1'b1;
      @(negedge clk);
      chk({hlda, bus_oe, ad_oe, ale} == 4'b1000, "R9 hold beats request",
          32'({hlda, bus_oe, ad_oe, ale}), 32'h8);
      repeat (2) @(negedge clk);
      chk({hlda, ale} == 2'b10, "R9 grant kept", 32'({hlda, ale}), 32'h2);
      hold = 1'b0;
      @(negedge clk);
      chk({hlda, bus_oe, ale} == 3'b010, "R10 release", 32'({hlda, bus_oe, ale}), 32'h2);
      @(negedge clk);
      chk(ale == 1'b1, "R10 pending request starts", 32'(ale), 32'h1);
      wait_done();

      // R9: hold raised during T2 of a read
      @(negedge clk);
      req_write = 1'b0; req_addr = 20'h00200; req_valid = 1'b1; ready = 1'b1;
      @(negedge clk); // T1
      @(negedge clk); // T2
      hold = 1'b1;
      @(negedge clk); // T3
      chk({rd_n, hlda} == 2'b00, "R9 cycle not cut", 32'({rd_n, hlda}), 32'h0);
      @(negedge clk); // T4
      chk({cyc_done, hlda} == 2'b10, "R9 done before grant", 32'({cyc_done, hlda}), 32'h2);
      req_valid = 1'b0;
      @(negedge clk);
      chk({hlda, bus_oe, ad_oe} == 3'b100, "R9 grant after T4",
          32'({hlda, bus_oe, ad_oe}), 32'h4);
      hold = 1'b0;
      @(negedge clk);
      chk(hlda == 1'b0, "R10 grant dropped", 32'(hlda), 32'h0);

      // R11: reset edge in the middle of a write
      @(negedge clk);
      req_write = 1'b1; req_wdata = 16'h7777; req_addr = 20'h00400; req_valid = 1'b1;
      @(negedge clk); // T1
      @(negedge clk); // T2
      chk(wr_n == 1'b0, "R4 write command before abort", 32'(wr_n), 32'h0);
      rst = 1'b1; req_valid = 1'b0;
      @(negedge clk);
      idle_pins("R11 abort");
      repeat (3) @(negedge clk);
      rst = 1'b0;
      run_cycle(VECS[0]);

      // R11: reset pulse shorter than the minimum
      apply_reset(2);
      req_addr = 20'h00800; req_write = 1'b0; req_valid = 1'b1;
      repeat (3) @(negedge clk);
      chk(ale == 1'b0, "R11 short reset blocks requests", 32'(ale), 32'h0);
      req_valid = 1'b0; hold = 1'b1;
      repeat (2) @(negedge clk);
      chk(hlda == 1'b0, "R11 short reset blocks hold", 32'(hlda), 32'h0);
      hold = 1'b0;
      apply_reset(4);
      run_cycle(VECS[2]);

      report();
   end

endmodule